// File: doc/BRIEF.md
# Dual-Mode Processor Counter Timer

This block is a counter/timer dedicated to one processor. It sits behind a 32-bit word register port and advances its count by one unit on every cycle in which a fixed-rate tick enable is high. The count sits at bit 9 of the register words, and bits 8:0 always read as zero. An external mode input picks one of two personalities for the same counter.

In limit mode the counter is 22 bits wide, shown as bits 30:9. It climbs toward a programmable limit. When it arrives, a reached flag and the interrupt output go high. A limit of zero selects free-running up to the largest count. In user mode the same storage becomes a 54-bit count, shown as a 64-bit value split across a high and a low word. Software can preload it through those two words and can start and stop it through a run bit. This mode never interrupts.

The register port is a plain single-cycle interface. A write is taken at the clock edge where `reg_wr` is high. Read data is combinational from the current state while `reg_rd` is high. Any side effect of a read takes place at that same edge. No back-pressure exists: every access completes in the cycle it is presented.

Top module: `proc_cnt_timer`

## Requirements
- R1: After reset the limit, the count, the reached flag and the interrupt are zero, and the run bit reads 1.
- R2: In limit mode each cycle with `tick_en` high adds 1 to the count, which reads at bits 30:9 of word 1. Bits 8:0 of that word read zero.
- R3: In limit mode, a tick that makes the count equal to the nonzero limit sets the reached flag and raises `irq` at the same edge. The reached flag reads at bit 31 of words 0 and 1. The next tick reloads the count to zero.
- R4: In limit mode, a read of word 0 returns the reached flag in bit 31 and the limit in bits 30:9. That read clears both the reached flag and `irq`.
- R5: With a limit of zero, the count runs up to 0x7FFFFE00 as read from word 1. That tick sets the reached flag and `irq`, and the next tick wraps the count to zero.
- R6: In limit mode, a write to word 0 lowers `irq`, stores the data masked with 0x7FFFFE00 as the new limit, and restarts the count at zero.
- R7: A write to word 2 stores the masked limit and leaves the current count unchanged.
- R8: In user mode, word 0 holds bits 62:32 of the count in its bits 30:0 and the reached flag in bit 31. Word 1 holds bits 31:9 of the count, with bits 8:0 reading zero. A write to either word loads that part of the count and clears the reached flag. The reached flag is set when the count wraps past its maximum.
- R9: While `user_mode` stays high, `irq` stays low.
- R10: In user mode, a write to word 3 sets the run bit from data bit 0. The count advances only while the run bit is 1. Word 3 reads the run bit in bit 0.
- R11: A rise of `user_mode` lowers `irq` and clears the run bit. A fall of `user_mode` sets the run bit, and counting resumes in limit mode.
- R12: Reads of words 2 and 4 to 7 return zero. In limit mode a write to word 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-advance enable, one unit per high cycle |
| user_mode | input | 1 | 1 selects user-timer mode, 0 limit mode |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (enables read side effects) |
| reg_addr | input | 3 | Word index (byte address bits 4:2) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request, limit mode only |

## Verification
The limit-mode counter is tested with several kinds of limit:
- A small limit written through word 0 shows the hit edge and the reload that follows it.
- A limit enlarged through word 2 partway through a count shows that the running count is kept rather than restarted.
- An all-ones write shows the masking, and shows that a write lowers `irq` without touching the reached flag.
- A zero limit, reached by preloading a count near the top in user mode, separates free-run wrap from a programmed hit.

In user mode the bench covers several more cases:
- Ticks while stopped show that the run gate works.
- A low-word value at its maximum shows the carry into the high word.
- An all-ones preload shows the wrap that sets the reached flag without raising `irq`.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  typedef enum logic [2:0] {
    WSEL_LIMIT  = 3'd0,
    WSEL_COUNT  = 3'd1,
    WSEL_LIM_NR = 3'd2,
    WSEL_RUN    = 3'd3
  } word_sel_e;

  typedef struct packed {
    logic lim_wr;
    logic lim_nr_wr;
    logic hi_wr;
    logic lo_wr;
    logic run_wr;
    logic lim_rd;
  } tmr_cmd_t;

endpackage

// File: rtl/tmr_regdec.sv
`timescale 1ns/1ps
module tmr_regdec
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              user_i,
  output tmr_cmd_t          cmd_o
);

  logic sel_lim, sel_cnt, sel_nr, sel_run;

  always_comb begin
    sel_lim = (addr_i == ADDR_W'(WSEL_LIMIT));
    sel_cnt = (addr_i == ADDR_W'(WSEL_COUNT));
    sel_nr  = (addr_i == ADDR_W'(WSEL_LIM_NR));
    sel_run = (addr_i == ADDR_W'(WSEL_RUN));

    cmd_o.lim_wr    = wr_i && sel_lim && !user_i;
    cmd_o.hi_wr     = wr_i && sel_lim && user_i;
    cmd_o.lo_wr     = wr_i && sel_cnt && user_i;
    cmd_o.lim_nr_wr = wr_i && sel_nr;
    cmd_o.run_wr    = wr_i && sel_run && user_i;
    cmd_o.lim_rd    = rd_i && sel_lim && !user_i;
  end

endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
  import tmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TICK_LSB = 9,
  localparam int LIM_W   = DATA_W - 1 - TICK_LSB,
  localparam int LO_W    = DATA_W - TICK_LSB,
  localparam int USR_W   = 2*DATA_W - 1 - TICK_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              user_i,
  input  tmr_cmd_t          cmd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [USR_W-1:0]  cnt_o,
  output logic [LIM_W-1:0]  lim_o,
  output logic              reached_o,
  output logic              running_o,
  output logic              irq_o
);

  localparam int HI_W = USR_W - LO_W;

  logic [USR_W-1:0] cnt_q;
  logic [LIM_W-1:0] lim_q;
  logic             reached_q, running_q, irq_q, mode_q;

  logic [LIM_W-1:0] lim_eff, lim_cnt, lim_inc;
  logic             at_lim, hit, usr_wrap, advance, enter, leave;
  logic [USR_W-1:0] cnt_nxt;

  always_comb begin
    lim_eff  = (lim_q == '0) ? '1 : lim_q;
    lim_cnt  = cnt_q[LIM_W-1:0];
    lim_inc  = lim_cnt + 1'b1;
    at_lim   = (lim_cnt == lim_eff);
    advance  = tick_i && (!user_i || running_q);
    hit      = advance && !user_i && !at_lim && (lim_inc == lim_eff);
    usr_wrap = advance && user_i && (&cnt_q);
    enter    = user_i && !mode_q;
    leave    = !user_i && mode_q;
    if (user_i)      cnt_nxt = cnt_q + 1'b1;
    else if (at_lim) cnt_nxt = '0;
    else             cnt_nxt = {{(USR_W-LIM_W){1'b0}}, lim_inc};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      lim_q     <= '0;
      reached_q <= 1'b0;
      running_q <= 1'b1;
      irq_q     <= 1'b0;
      mode_q    <= 1'b0;
    end else begin
      mode_q <= user_i;
      if (advance) cnt_q <= cnt_nxt;
      if (hit) begin
        reached_q <= 1'b1;
        irq_q     <= 1'b1;
      end else if (cmd_i.lim_rd) begin
        reached_q <= 1'b0;
        irq_q     <= 1'b0;
      end
      if (usr_wrap) reached_q <= 1'b1;
      if (cmd_i.lim_wr) begin
        lim_q <= wdata_i[DATA_W-2:TICK_LSB];
        cnt_q <= '0;
        irq_q <= 1'b0;
      end
      if (cmd_i.lim_nr_wr) lim_q <= wdata_i[DATA_W-2:TICK_LSB];
      if (cmd_i.hi_wr) begin
        cnt_q[USR_W-1:LO_W] <= wdata_i[HI_W-1:0];
        reached_q           <= 1'b0;
      end
      if (cmd_i.lo_wr) begin
        cnt_q[LO_W-1:0] <= wdata_i[DATA_W-1:TICK_LSB];
        reached_q       <= 1'b0;
      end
      if (cmd_i.run_wr) running_q <= wdata_i[0];
      if (enter) begin
        irq_q     <= 1'b0;
        running_q <= 1'b0;
      end
      if (leave) begin
        running_q              <= 1'b1;
        cnt_q[USR_W-1:LIM_W]   <= '0;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign lim_o     = lim_q;
  assign reached_o = reached_q;
  assign running_o = running_q;
  assign irq_o     = irq_q;

  // R2: a plain limit-mode tick below the limit adds exactly one unit
  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !user_i && !mode_q && !at_lim && !cmd_i.lim_wr)
      |=> (cnt_q[LIM_W-1:0] == LIM_W'($past(cnt_q[LIM_W-1:0]) + 1'b1)));

  // R3: a tick taken while sitting at the limit reloads to zero
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !user_i && !mode_q && at_lim && !cmd_i.lim_wr)
      |=> (cnt_q[LIM_W-1:0] == '0));

  // R4: reading the limit word drops the flag and the interrupt
  p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i.lim_rd && !hit) |=> (!reached_q && !irq_q));

  // R6: limit write restarts the count and lowers the interrupt
  p_limit_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i.lim_wr |=> (cnt_q == '0 && !irq_q));

  // R9: no interrupt while user mode is held
  p_no_irq_user_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (user_i && mode_q) |-> !irq_q);

  // R10: run bit follows the status write
  p_run_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i.run_wr && mode_q) |=> (running_q == $past(wdata_i[0])));

  // R11: entering user mode stops the counter and drops the interrupt
  p_enter_user_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(user_i) |=> (!running_q && !irq_q));

  // R11: leaving user mode starts the counter
  p_leave_user_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(user_i) |=> running_q);

endmodule

// File: rtl/tmr_rdmux.sv
`timescale 1ns/1ps
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TICK_LSB = 9,
  parameter int ADDR_W   = 3,
  localparam int LIM_W   = DATA_W - 1 - TICK_LSB,
  localparam int LO_W    = DATA_W - TICK_LSB,
  localparam int USR_W   = 2*DATA_W - 1 - TICK_LSB
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              user_i,
  input  logic [USR_W-1:0]  cnt_i,
  input  logic [LIM_W-1:0]  lim_i,
  input  logic              reached_i,
  input  logic              running_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam logic [TICK_LSB-1:0] LOW_ZERO = '0;

  always_comb begin
    unique case (addr_i)
      ADDR_W'(WSEL_LIMIT):
        rdata_o = user_i ? {reached_i, cnt_i[USR_W-1:LO_W]}
                         : {reached_i, lim_i, LOW_ZERO};
      ADDR_W'(WSEL_COUNT):
        rdata_o = user_i ? {cnt_i[LO_W-1:0], LOW_ZERO}
                         : {reached_i, cnt_i[LIM_W-1:0], LOW_ZERO};
      ADDR_W'(WSEL_RUN):
        rdata_o = {{(DATA_W-1){1'b0}}, running_i};
      default:
        rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/proc_cnt_timer.sv
`timescale 1ns/1ps
module proc_cnt_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TICK_LSB = 9,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              user_mode,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  localparam int LIM_W = DATA_W - 1 - TICK_LSB;
  localparam int USR_W = 2*DATA_W - 1 - TICK_LSB;

  tmr_cmd_t         cmd;
  logic [USR_W-1:0] cnt;
  logic [LIM_W-1:0] lim;
  logic             reached, running;

  tmr_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i   (reg_wr),
    .rd_i   (reg_rd),
    .addr_i (reg_addr),
    .user_i (user_mode),
    .cmd_o  (cmd)
  );

  tmr_core #(.DATA_W(DATA_W), .TICK_LSB(TICK_LSB)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_en),
    .user_i    (user_mode),
    .cmd_i     (cmd),
    .wdata_i   (reg_wdata),
    .cnt_o     (cnt),
    .lim_o     (lim),
    .reached_o (reached),
    .running_o (running),
    .irq_o     (irq)
  );

  tmr_rdmux #(.DATA_W(DATA_W), .TICK_LSB(TICK_LSB), .ADDR_W(ADDR_W)) u_rd (
    .addr_i    (reg_addr),
    .user_i    (user_mode),
    .cnt_i     (cnt),
    .lim_i     (lim),
    .reached_i (reached),
    .running_i (running),
    .rdata_o   (reg_rdata)
  );

endmodule

// File: tb/proc_cnt_timer_tb.sv
`timescale 1ns/1ps
module proc_cnt_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        user_mode = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  proc_cnt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .user_mode(user_mode),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(posedge clk); #1; tick_en = 1'b0;
    end
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk); user_mode = m;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(3'd1, v); chk("R1 count", v, 32'h0);
    rd(3'd0, v); chk("R1 limit", v, 32'h0);
    rd(3'd3, v); chk("R1 running", v, 32'h1);
  endtask

  task automatic t_tick;
    logic [31:0] v;
    ticks(3);
    rd(3'd1, v); chk("R2 three ticks", v, 32'h600);
  endtask

  task automatic t_limit_hit;
    logic [31:0] v;
    wr(3'd0, 32'h0000_0A00);
    rd(3'd1, v); chk("R6 restart", v, 32'h0);
    ticks(4);
    chk("R3 irq before hit", {31'b0, irq}, 32'h0);
    ticks(1);
    chk("R3 irq at hit", {31'b0, irq}, 32'h1);
    rd(3'd1, v); chk("R3 count at hit", v, 32'h8000_0A00);
    ticks(1);
    rd(3'd1, v); chk("R3 reload", v, 32'h8000_0000);
    rd(3'd0, v); chk("R4 limit read", v, 32'h8000_0A00);
    chk("R4 irq cleared", {31'b0, irq}, 32'h0);
    rd(3'd1, v); chk("R4 flag cleared", v, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    ticks(5);
    chk("R6 irq up", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'hFFFF_FFFF);
    chk("R6 irq lowered", {31'b0, irq}, 32'h0);
    rd(3'd0, v); chk("R6 masked, flag kept", v, 32'hFFFF_FE00);
    rd(3'd0, v); chk("R6 masked limit", v, 32'h7FFF_FE00);
    rd(3'd1, v); chk("R6 count zero", v, 32'h0);
  endtask

  task automatic t_norst;
    logic [31:0] v;
    wr(3'd0, 32'h0000_0600);
    ticks(2);
    wr(3'd2, 32'h0000_1400);
    rd(3'd1, v); chk("R7 count kept", v, 32'h400);
    ticks(7);
    chk("R7 no early irq", {31'b0, irq}, 32'h0);
    ticks(1);
    chk("R7 irq at new limit", {31'b0, irq}, 32'h1);
    rd(3'd0, v); chk("R7 new limit", v, 32'h8000_1400);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(3'd5, v); chk("R12 word5", v, 32'h0);
    rd(3'd2, v); chk("R12 word2", v, 32'h0);
    wr(3'd3, 32'h0);
    rd(3'd3, v); chk("R12 run kept", v, 32'h1);
    ticks(1);
    rd(3'd1, v); chk("R12 reload still counts", v, 32'h0);
    ticks(2);
    rd(3'd1, v); chk("R12 counting", v, 32'h400);
  endtask

  task automatic t_user;
    logic [31:0] v;
    wr(3'd0, 32'h0000_0400);
    ticks(2);
    chk("R11 irq before entry", {31'b0, irq}, 32'h1);
    set_mode(1'b1);
    chk("R11 irq lowered", {31'b0, irq}, 32'h0);
    rd(3'd3, v); chk("R11 stopped", v, 32'h0);
    rd(3'd0, v); chk("R8 hi word with flag", v, 32'h8000_0000);
    rd(3'd1, v); chk("R8 lo word", v, 32'h400);
    wr(3'd0, 32'h0001_2345);
    wr(3'd1, 32'hABCD_E200);
    rd(3'd0, v); chk("R8 hi load", v, 32'h0001_2345);
    rd(3'd1, v); chk("R8 lo load", v, 32'hABCD_E200);
    ticks(2);
    rd(3'd1, v); chk("R10 stopped", v, 32'hABCD_E200);
    wr(3'd3, 32'h1);
    rd(3'd3, v); chk("R10 run read", v, 32'h1);
    ticks(3);
    rd(3'd1, v); chk("R10 running", v, 32'hABCD_E800);
    wr(3'd3, 32'h0);
    ticks(1);
    rd(3'd1, v); chk("R10 stop again", v, 32'hABCD_E800);
    wr(3'd1, 32'hFFFF_FE00);
    wr(3'd3, 32'h1);
    ticks(1);
    rd(3'd1, v); chk("R8 carry lo", v, 32'h0);
    rd(3'd0, v); chk("R8 carry hi", v, 32'h0001_2346);
    wr(3'd0, 32'h7FFF_FFFF);
    wr(3'd1, 32'hFFFF_FE00);
    ticks(1);
    rd(3'd0, v); chk("R8 wrap flag", v, 32'h8000_0000);
    chk("R9 no irq on wrap", {31'b0, irq}, 32'h0);
    wr(3'd1, 32'h0);
    rd(3'd0, v); chk("R8 write clears flag", v, 32'h0);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_freerun;
    logic [31:0] v;
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h7FFF_FC00);
    set_mode(1'b0);
    rd(3'd3, v); chk("R11 run on return", v, 32'h1);
    rd(3'd1, v); chk("R5 preload", v, 32'h7FFF_FC00);
    ticks(1);
    rd(3'd1, v); chk("R5 top count", v, 32'hFFFF_FE00);
    chk("R5 irq", {31'b0, irq}, 32'h1);
    ticks(1);
    rd(3'd1, v); chk("R5 wrap", v, 32'h8000_0000);
    rd(3'd0, v); chk("R5 zero limit", v, 32'h8000_0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_tick();
    t_limit_hit();
    t_mask();
    t_norst();
    t_unmapped();
    t_user();
    t_freerun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule